// File: doc/BRIEF.md
# Serial ADC Channel Reader

This block is an SPI master that reads one channel of an eight-channel, 8-bit serial analog-to-digital converter. A one-cycle request with a 3-bit channel number starts one conversion. The block pulls chip select low and clocks out a 14-bit frame. The frame opens with a two-bit start prefix, then carries the channel number with its bits in a shuffled order, then pads with zeros. In the same frame it shifts in the converter's reply and keeps the last eight returned bits as the result.

The serial clock idles low. The block drives a new data bit on each falling edge and samples the reply on each rising edge, most significant bit first (mode 0). A parameter sets the length of each SCK half period in system clocks. At the 100 MHz default this gives just under 600 kHz. When the frame ends, chip select rises and a single-cycle done pulse marks the new result. The result is held until the next conversion finishes.

Top module: `adc_chan_reader`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, mosi_o is 0, done_o is 0 and result_o is 0x00.
- R2: Transmit bits 1 and 2 of every frame are 1. Bit 1 is the first bit sent.
- R3: Transmit bit 3 carries ch_i[0], bit 4 carries ch_i[2] and bit 5 carries ch_i[1]. For example, channel 1 sends 100 and channel 6 sends 011.
- R4: Transmit bits 6 to 14 are 0, and mosi_o is 0 whenever cs_no is 1.
- R5: sck_o is 0 while idle. Within a frame, each bit spends HALF_CYC clocks with sck_o low and then HALF_CYC clocks with sck_o high. The first rising edge comes HALF_CYC clocks after cs_no falls. mosi_o changes only on falling SCK edges.
- R6: result_o is made from the miso_i values sampled at the rising SCK edges of bits 7 to 14. Bit 7 lands in result_o[7] and bit 14 lands in result_o[0]. The values returned during bits 1 to 6 have no effect.
- R7: done_o is high for exactly one clock. It rises in the same cycle that cs_no returns to 1, 28*HALF_CYC clocks after the cycle in which the request was accepted.
- R8: result_o changes only in the cycle in which done_o is high.
- R9: A request seen while a frame is in progress, including the cycle in which done_o rises, is dropped. A request in any later idle cycle is accepted.
- R10: A frame is exactly 14 SCK periods long, and cs_no stays 0 for 28*HALF_CYC consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a conversion (sampled when idle) |
| ch_i | input | 3 | Channel number for the request |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| result_o | output | 8 | Last conversion result |
| sck_o | output | 1 | SPI clock, idles low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Data to the converter |
| miso_i | input | 1 | Data from the converter |

## Verification
Two events can land in the same cycle: the end of a frame, when done_o pulses and chip select rises, and a new request. The bench raises req_i so that it is sampled at exactly the edge where the frame closes, and holds it for one more cycle. The reference model expects the first sample to be dropped and the second to start a fresh frame one cycle later. Every clock it compares chip select, SCK, MOSI, done and result against the model, so a request wrongly taken at the closing edge shows up as a one-cycle shift of the whole next frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } rd_state_e;

  localparam int unsigned CH_W = 3;

  // prefix 11, then channel bits 0,2,1, rest zero
  function automatic logic [13:0] build_frame(input logic [CH_W-1:0] ch);
    logic [13:0] f;
    f      = '0;
    f[13]  = 1'b1;
    f[12]  = 1'b1;
    f[11]  = ch[0];
    f[10]  = ch[2];
    f[9]   = ch[1];
    return f;
  endfunction
endpackage

// File: rtl/adc_sck_div.sv
module adc_sck_div #(
  parameter int unsigned HALF_CYC = 84
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_shifter.sv
module adc_shifter #(
  parameter int unsigned FRAME_BITS = 14,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  rise_i,
  input  logic                  fall_i,
  input  logic                  cap_en_i,
  input  logic                  miso_i,
  output logic                  tx_bit_o,
  output logic [DATA_W-1:0]     rx_o
);
  logic [FRAME_BITS-1:0] tx_q;
  logic [DATA_W-1:0]     rx_q;

  assign tx_bit_o = tx_q[FRAME_BITS-1];
  assign rx_o     = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '0;
    else if (load_i) tx_q <= frame_i;
    else if (fall_i) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rx_q <= '0;
    else if (rise_i && cap_en_i) rx_q <= {rx_q[DATA_W-2:0], miso_i};
  end
endmodule

// File: rtl/adc_chan_reader.sv
module adc_chan_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_CYC   = 84,
  parameter int unsigned FRAME_BITS = 14,
  parameter int unsigned DATA_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CH_W-1:0]   ch_i,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned BW        = $clog2(FRAME_BITS);
  localparam int unsigned CAP_FIRST = FRAME_BITS - DATA_W;  // zero-based index
  localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] CAP_IDX  = BW'(CAP_FIRST);

  rd_state_e         st_q;
  logic              sck_q, cs_n_q, done_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] res_q, rx_w;
  logic              tick_w, start_w, rise_w, fall_w, tx_bit_w, last_w;

  assign start_w = (st_q == ST_IDLE) && req_i;
  assign rise_w  = tick_w && !sck_q;
  assign fall_w  = tick_w && sck_q;
  assign last_w  = (bit_q == LAST_IDX);

  adc_sck_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q == ST_XFER),
    .tick_o (tick_w)
  );

  adc_shifter #(.FRAME_BITS(FRAME_BITS), .DATA_W(DATA_W)) u_shf (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_w),
    .frame_i  (build_frame(ch_i)),
    .rise_i   (rise_w),
    .fall_i   (fall_w),
    .cap_en_i (bit_q >= CAP_IDX),
    .miso_i   (miso_i),
    .tx_bit_o (tx_bit_w),
    .rx_o     (rx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sck_q  <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      bit_q  <= '0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q   <= ST_XFER;
          cs_n_q <= 1'b0;
          sck_q  <= 1'b0;
          bit_q  <= '0;
        end
        ST_XFER: if (tick_w) begin
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            if (last_w) begin
              st_q   <= ST_IDLE;
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              res_q  <= rx_w;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sck_o    = sck_q;
  assign cs_no    = cs_n_q;
  assign done_o   = done_q;
  assign result_o = res_q;
  assign mosi_o   = !cs_n_q && tx_bit_w;
endmodule

// File: rtl/adc_chan_reader_chk.sv
module adc_chan_reader_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [DATA_W-1:0] result_o,
  input logic              sck_o,
  input logic              cs_no,
  input logic              mosi_o
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R7

  AST_DONE_WITH_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && !$past(cs_no)));  // R7

  AST_IDLE_LINES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (!mosi_o && !sck_o));  // R4

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));  // R8

  AST_MOSI_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$fell(cs_no) && !$fell(sck_o)) |-> $stable(mosi_o));  // R5
endmodule

bind adc_chan_reader adc_chan_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .result_o (result_o),
  .sck_o    (sck_o),
  .cs_no    (cs_no),
  .mosi_o   (mosi_o)
);

// File: tb/tb_adc_chan_reader.sv
module tb_adc_chan_reader;
  localparam int H = 84;
  localparam int FRAME_CYC = 28 * H;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [2:0] ch_i = '0;
  logic       done_o, sck_o, cs_no, mosi_o;
  logic       miso_i = 1'b0;
  logic [7:0] result_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  bit        m_busy = 0;
  int        m_n = 0;
  bit [13:0] m_frame = '0;
  bit [13:0] m_word = '0;
  bit [13:0] slave_word = '0;
  bit [7:0]  m_result = '0;
  bit        m_done = 0;
  bit        cmp_en = 0;

  adc_chan_reader dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ch_i(ch_i),
    .done_o(done_o), .result_o(result_o), .sck_o(sck_o),
    .cs_no(cs_no), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  always #5 clk_i = ~clk_i;

  function automatic bit [13:0] exp_frame(input bit [2:0] c);
    bit [13:0] f = '0;
    f[13] = 1; f[12] = 1;          // R2 prefix
    f[11] = c[0]; f[10] = c[2]; f[9] = c[1];  // R3 order
    return f;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    cycles++;
    m_done = 0;
    if (!rst_ni) begin
      m_busy = 0; m_result = '0;
    end else if (m_busy) begin
      m_n++;
      if (m_n == FRAME_CYC) begin
        m_busy = 0; m_done = 1; m_result = m_word[7:0];
      end
    end else if (req_i) begin
      m_busy = 1; m_n = 0; m_frame = exp_frame(ch_i); m_word = slave_word;
    end
  end

  always @(negedge clk_i) begin
    if (m_busy) miso_i <= m_word[13 - m_n / (2 * H)];
    else        miso_i <= 1'($urandom);
    if (cmp_en && rst_ni) begin
      bit e_cs, e_sck, e_mosi;
      int k;
      k = m_n / (2 * H);
      e_cs   = !m_busy;
      e_sck  = m_busy && ((m_n / H) % 2 == 1);
      e_mosi = m_busy && m_frame[13 - k];
      chk(cs_no == e_cs, "R10 cs_no", cs_no, e_cs);
      chk(sck_o == e_sck, "R5 sck_o", sck_o, e_sck);
      if (!m_busy)     chk(mosi_o == e_mosi, "R4 mosi idle", mosi_o, e_mosi);
      else if (k < 2)  chk(mosi_o == e_mosi, "R2 mosi prefix", mosi_o, e_mosi);
      else if (k < 5)  chk(mosi_o == e_mosi, "R3 mosi channel", mosi_o, e_mosi);
      else             chk(mosi_o == e_mosi, "R4 mosi pad", mosi_o, e_mosi);
      chk(done_o == m_done, "R7 done_o", done_o, m_done);
      chk(result_o == m_result, m_done ? "R6 result_o" : "R8 result_o", result_o, m_result);
    end
  end

  task automatic request(input bit [2:0] c, input bit [13:0] w);
    @(negedge clk_i);
    slave_word = w;
    req_i = 1; ch_i = c;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic wait_done();
    @(negedge clk_i);
    while (!m_done) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cs_no && !sck_o && !mosi_o && !done_o && result_o == 8'h00,
        "R1 reset state", {cs_no, sck_o, mosi_o, done_o, result_o}, 12'h800);
    rst_ni = 1;
    cmp_en = 1;
    repeat (4) @(negedge clk_i);

    // all channels, varied replies; top six returned bits are noise (R6)
    for (int c = 0; c < 8; c++) begin
      bit [13:0] w;
      w = {6'(c * 11 + 37), 8'(c * 37 + 5)};
      request(3'(c), w);
      wait_done();
      chk(result_o == w[7:0], "R6 result channel", result_o, w[7:0]);
      repeat (5) @(negedge clk_i);
    end
    request(3'd5, 14'h3FFF); wait_done();
    chk(result_o == 8'hFF, "R6 full scale", result_o, 8'hFF);
    request(3'd2, 14'h3F00); wait_done();
    chk(result_o == 8'h00, "R6 zero with noisy prefix", result_o, 8'h00);

    // R10: chip-select low time
    begin
      int low_cnt;
      low_cnt = 0;
      request(3'd3, 14'h0A5);
      while (!cs_no) begin low_cnt++; @(negedge clk_i); end
      chk(low_cnt == FRAME_CYC, "R10 frame length", low_cnt, FRAME_CYC);
    end

    // R9: request mid-frame is dropped
    request(3'd1, 14'h012C);
    repeat (10 * H) @(negedge clk_i);
    slave_word = 14'h0077;
    req_i = 1; ch_i = 3'd6;
    @(negedge clk_i);
    req_i = 0;
    wait_done();
    chk(result_o == 8'h2C, "R9 mid-frame request dropped", result_o, 8'h2C);
    repeat (3) @(negedge clk_i);
    chk(cs_no == 1, "R9 no second frame", cs_no, 1);

    // R9: request at the closing edge dropped, next cycle accepted
    request(3'd4, 14'h0031);
    while (m_n != FRAME_CYC - 1) @(negedge clk_i);
    slave_word = 14'h00C3;
    req_i = 1; ch_i = 3'd7;
    @(negedge clk_i);
    chk(done_o && cs_no, "R9 done at collision edge", {done_o, cs_no}, 3);
    @(negedge clk_i);
    req_i = 0;
    chk(!cs_no, "R9 accepted after done", cs_no, 0);
    wait_done();
    chk(result_o == 8'hC3, "R9 back-to-back result", result_o, 8'hC3);

    repeat (10) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule